// File: doc/BRIEF.md
# Multi-Channel Pulse Period and High-Time Meter

This block measures a bank of independent digital inputs. Every input passes through a two-flop synchroniser, and both of its edges are detected. A per-channel counter, running on the system clock, gives two values. The period is the number of clock cycles between successive rising edges. The high time is the number of cycles from a rising edge to the falling edge that follows it. Measurement runs continuously, whatever the input rate.

A free-running divider produces a snapshot tick at a programmable interval. On each tick the block copies three things into a staging set:

- the newest completed result of every channel;
- a per-channel stale flag;
- one shared timestamp taken from a free-running timebase.

The staging set is then published to a host-visible set. A host reads that set through a word-addressed read port. While the host holds the read-hold input, the visible set stays frozen. A newer snapshot waits in staging and is published on the first cycle after the hold drops. A host that reads late therefore never sees a mixed set, and its read timing adds no jitter to the measurement.

Top module: `pulse_meter_bank`

## Requirements
- R1: The period of channel c is the count of clock cycles between two successive synchronised rising edges. It is read at word address 1+2c. The first rising edge after reset yields no period.
- R2: The high time of channel c is the count of clock cycles from a rising edge to the next falling edge. It is read in bits CW-1:0 of word address 2+2c. A falling edge before any rising edge since reset is ignored.
- R3: Measurement continues between snapshots. Each snapshot carries the most recently completed period and high time. A channel that stops toggling keeps its last completed values.
- R4: The period and high-time counts saturate at 2^CW-1 and never wrap.
- R5: Bit 31 of the high-time word is the stale flag. It is 1 when no rising edge occurred between the previous snapshot tick and this one, and 0 otherwise.
- R6: A snapshot tick occurs once every tick_div clock cycles. Word address 0 returns the free-running timebase value at the tick, so snapshots published back to back carry timestamps that differ by the interval.
- R7: While rd_hold is 1, the visible set does not change and snap_pub stays 0. A pending snapshot is published on the first cycle in which rd_hold is 0. snap_pub is 1 in that cycle, and the new data are readable from the next cycle.
- R8: After reset, every word reads 0. A word address above 2*NCH reads 0.
- R9: A tick_div value of 0 acts as an interval of 1, so a tick occurs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock and measurement timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | NCH | Asynchronous measured inputs, one bit per channel |
| tick_div | input | DIVW | Snapshot interval in clock cycles (0 acts as 1) |
| rd_hold | input | 1 | Freezes the host-visible set while 1 |
| rd_addr | input | AW | Word address of the host read |
| rd_data | output | 32 | Word read from the host-visible set |
| snap_pub | output | 1 | One-cycle pulse when a snapshot becomes visible |

## Verification
The bench builds the block with twelve channels, 8-bit measurement counters and a 12-bit divider. With 8-bit counters, both period and high-time saturation are reached with input periods of a few hundred cycles. The 12-bit divider allows intervals of 200 and 400 cycles, and the zero-interval case.

Channel inputs are clock-aligned square waves of known period and high time. Channel c uses a period offset by c, so a swap between channels or a wrong word address shows up as a wrong value. Holding the read port across several intervals shows whether staged snapshots leak into the visible set.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    WK_STAMP  = 2'd0,
    WK_PERIOD = 2'd1,
    WK_HIGH   = 2'd2,
    WK_NONE   = 2'd3
  } word_kind_e;

  // Snapshot interval in cycles; a zero setting acts as one.
  function automatic logic [31:0] eff_interval(input logic [31:0] setting);
    return (setting == 32'd0) ? 32'd1 : setting;
  endfunction

  // Word map: 0 = stamp, then a period/high pair per channel.
  function automatic word_kind_e word_kind(input int addr, input int nch);
    if (addr == 0) return WK_STAMP;
    if (addr > 2 * nch) return WK_NONE;
    return ((addr - 1) % 2 == 0) ? WK_PERIOD : WK_HIGH;
  endfunction

  function automatic int word_chan(input int addr);
    return (addr == 0) ? 0 : (addr - 1) / 2;
  endfunction

endpackage

// File: rtl/pm_divider.sv
module pm_divider
  import pm_pkg::*;
#(
  parameter int DIVW = 16,
  parameter int TSW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] tick_div,
  output logic            tick,
  output logic [TSW-1:0]  stamp
);

  logic [31:0] dcnt;
  logic [31:0] n_eff;

  assign n_eff = eff_interval(32'(tick_div));
  // A compare against >= recovers at once when the interval is lowered.
  assign tick  = (dcnt + 32'd1) >= n_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt  <= '0;
      stamp <= '0;
    end else begin
      dcnt  <= tick ? 32'd0 : dcnt + 32'd1;
      stamp <= stamp + 1'b1;
    end
  end

  // Ticks are never adjacent unless the interval is one or has just changed.
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && n_eff > 32'd1) |=> (!tick || tick_div != $past(tick_div)));

endmodule

// File: rtl/pm_channel.sv
module pm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig,
  input  logic          tick,
  output logic [CW-1:0] period_q,
  output logic [CW-1:0] high_q,
  output logic          win_rise
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic s1, s2, s3;
  logic rise_ev, fall_ev;
  logic seen;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  assign rise_ev = s2 & ~s3;
  assign fall_ev = ~s2 & s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      s3       <= 1'b0;
      cnt      <= '0;
      seen     <= 1'b0;
      period_q <= '0;
      high_q   <= '0;
      win_rise <= 1'b0;
    end else begin
      s1 <= sig;
      s2 <= s1;
      s3 <= s2;
      cnt <= rise_ev ? {{(CW-1){1'b0}}, 1'b1} : sat_inc(cnt);
      if (rise_ev) seen <= 1'b1;
      if (rise_ev && seen) period_q <= cnt;
      if (fall_ev && seen) high_q <= cnt;
      // A rise in the tick cycle belongs to the next window.
      win_rise <= rise_ev | (win_rise & ~tick);
    end
  end

  p_period_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && seen && cnt == CMAX) |=> (period_q == CMAX));

endmodule

// File: rtl/pulse_meter_bank.sv
module pulse_meter_bank
  import pm_pkg::*;
#(
  parameter int NCH  = 12,
  parameter int CW   = 16,
  parameter int TSW  = 32,
  parameter int DIVW = 16,
  parameter int AW   = $clog2(2 * NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    sig_in,
  input  logic [DIVW-1:0]   tick_div,
  input  logic              rd_hold,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              snap_pub
);

  localparam int CHW = $clog2(NCH);

  logic           tick;
  logic [TSW-1:0] stamp;
  logic [CW-1:0]  ch_per [NCH];
  logic [CW-1:0]  ch_hi  [NCH];
  logic [NCH-1:0] ch_win;

  logic [TSW-1:0] stg_ts, vis_ts;
  logic [CW-1:0]  stg_per [NCH];
  logic [CW-1:0]  stg_hi  [NCH];
  logic [CW-1:0]  vis_per [NCH];
  logic [CW-1:0]  vis_hi  [NCH];
  logic [NCH-1:0] stg_stale, vis_stale;
  logic           pending;

  pm_divider #(.DIVW(DIVW), .TSW(TSW)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .tick(tick), .stamp(stamp)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .sig(sig_in[c]), .tick(tick),
      .period_q(ch_per[c]), .high_q(ch_hi[c]), .win_rise(ch_win[c])
    );
  end

  assign snap_pub = pending & ~rd_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_ts    <= '0;
      vis_ts    <= '0;
      stg_stale <= '0;
      vis_stale <= '0;
      pending   <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        stg_per[c] <= '0;
        stg_hi[c]  <= '0;
        vis_per[c] <= '0;
        vis_hi[c]  <= '0;
      end
    end else begin
      if (tick) begin
        stg_ts    <= stamp;
        stg_stale <= ~ch_win;
        for (int c = 0; c < NCH; c++) begin
          stg_per[c] <= ch_per[c];
          stg_hi[c]  <= ch_hi[c];
        end
      end
      // Publishing copies the old staging contents, so a tick in the
      // same cycle leaves a fresh snapshot still pending.
      if (snap_pub) begin
        vis_ts    <= stg_ts;
        vis_stale <= stg_stale;
        for (int c = 0; c < NCH; c++) begin
          vis_per[c] <= stg_per[c];
          vis_hi[c]  <= stg_hi[c];
        end
      end
      pending <= tick | (pending & ~snap_pub);
    end
  end

  word_kind_e      kind;
  logic [CHW-1:0]  rch;

  always_comb begin
    kind    = word_kind(int'(rd_addr), NCH);
    rch     = CHW'(word_chan(int'(rd_addr)));
    rd_data = '0;
    case (kind)
      WK_STAMP:  rd_data = WORD_W'(vis_ts);
      WK_PERIOD: rd_data = WORD_W'(vis_per[rch]);
      WK_HIGH: begin
        rd_data[CW-1:0]     = vis_hi[rch];
        rd_data[WORD_W-1]   = vis_stale[rch];
      end
      default:   rd_data = '0;
    endcase
  end

  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold |=> ($stable(vis_ts) && $stable(vis_stale)));

  p_pub_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (snap_pub || rd_hold));

endmodule

// File: tb/sim_pulse_meter_bank.sv
module sim_pulse_meter_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 12;
  localparam int CW   = 8;
  localparam int DIVW = 12;
  localparam int AW   = $clog2(2 * NCH + 1);
  localparam int CMAX = (1 << CW) - 1;
  localparam int NVEC = 4;
  // Per vector: base period (channel c adds c), high time.
  localparam int VEC [NVEC][2] = '{'{10, 3}, '{25, 12}, '{7, 1}, '{40, 39}};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  sig = '0;
  logic [DIVW-1:0] tick_div = 12'd200;
  logic            rd_hold = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;
  logic            snap_pub;

  int total = 0;
  int bad = 0;
  int pp [NCH];
  int hh [NCH];
  int ph [NCH];

  pulse_meter_bank #(.NCH(NCH), .CW(CW), .TSW(32), .DIVW(DIVW)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .tick_div(tick_div),
    .rd_hold(rd_hold), .rd_addr(rd_addr), .rd_data(rd_data), .snap_pub(snap_pub)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Clock-aligned square waves; period 0 holds the line low.
  initial begin
    for (int c = 0; c < NCH; c++) begin pp[c] = 0; hh[c] = 0; ph[c] = 0; end
    forever begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pp[c] == 0) sig[c] = 1'b0;
        else begin
          ph[c] = ph[c] + 1;
          if (ph[c] >= pp[c]) ph[c] = 0;
          sig[c] = (ph[c] < hh[c]);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic wait_pub(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!snap_pub);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, t0, t1, h0;
    int holdviol;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    rd(0, d); chk("R8 stamp after reset", d, 0);
    rd(1, d); chk("R8 period after reset", d, 0);
    rd(2, d); chk("R8 high after reset", d, 0);

    // R1 R2 R3 R5: table of patterns
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < NCH; c++) begin
        pp[c] = VEC[v][0] + c;
        hh[c] = VEC[v][1];
      end
      wait_pub(3);
      for (int c = 0; c < NCH; c++) begin
        rd(1 + 2 * c, d); chk("R1 period", d, 32'(VEC[v][0] + c));
        rd(2 + 2 * c, d); chk("R2 R5 high/not stale", d, 32'(VEC[v][1]));
      end
    end

    // R6: stamps of back-to-back snapshots differ by the interval
    wait_pub(1); rd(0, t0);
    wait_pub(1); rd(0, t1);
    chk("R6 stamp step", t1 - t0, 200);
    chk("R6 stamp phase", t1 % 200, 199);

    // R8: out-of-range address
    rd(30, d); chk("R8 out of range", d, 0);
    rd(25, d); chk("R8 first out of range", d, 0);

    // R7: hold freezes the visible set
    wait_pub(1);
    @(negedge clk); rd_hold = 1'b1;
    rd(0, h0);
    holdviol = 0;
    for (int i = 0; i < 450; i++) begin
      @(negedge clk);
      #1 if (snap_pub) holdviol++;
    end
    chk("R7 no publish in hold", holdviol, 0);
    rd(0, d); chk("R7 stamp frozen", d, h0);
    @(negedge clk); rd_hold = 1'b0;
    #1 chk("R7 publish on release", {31'd0, snap_pub}, 1);
    rd(0, d);
    chk("R7 newest after release", ((d - h0) % 200 == 0 && d - h0 >= 400) ? 1 : 0, 1);

    // R4: saturation of period and high time
    tick_div = 12'd400;
    for (int c = 0; c < NCH; c++) begin
      pp[c] = 300;
      hh[c] = (c % 2 == 1) ? 280 : 5;
    end
    wait_pub(4);
    for (int c = 0; c < NCH; c++) begin
      rd(1 + 2 * c, d); chk("R4 period saturates", d, CMAX);
      rd(2 + 2 * c, d); chk("R4 high saturates", d, 32'(imin(hh[c], CMAX)));
    end

    // R5 R3: silent inputs go stale and keep their last values
    for (int c = 0; c < NCH; c++) pp[c] = 0;
    wait_pub(3);
    for (int c = 0; c < NCH; c++) begin
      rd(2 + 2 * c, d); chk("R5 stale bit", {31'd0, d[31]}, 1);
      rd(1 + 2 * c, d); chk("R3 last period kept", d, CMAX);
    end

    // R9: zero interval ticks every cycle
    tick_div = '0;
    repeat (5) @(negedge clk);
    rd(0, t0);
    rd(0, t1);
    chk("R9 zero interval step", t1 - t0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule